// File: doc/BRIEF.md
# DMA Request Line Router

This block sits in front of a four-channel DMA engine. It connects external request pins and their acknowledge pins to the engine's channels. Each channel can claim one request/acknowledge pair or none. Software gives each channel a configuration word that selects the pair, the sensing mode and the role of the shared terminate line.

The block synchronises the request pins, which are asynchronous. It turns each request pin into a per-channel transfer request, using either level or edge sensing and either polarity. It drives the acknowledge pin of the owning channel for as long as the engine strobes a transfer on that channel.

The terminate line is split into an input, an output and an output enable. Configured as an input, it tells the engine to stop a non-fly-by sequence after the current access. Configured as an output, it marks the final transfer of a sequence. A channel that owns no pair takes its transfer request from an internal peripheral request input.

Top module: `dmarr_top`

## Requirements
- R1: After reset, channel 0 owns pair 0 (pin A), channel 1 owns pair 1 (pin B), and channels 2 and 3 own no pair. Every channel starts in level mode, active high, with the terminate line unused (cfg_term = 0). cfg_err is 0.
- R2: A configuration write with cfg_pin_en = 1 that names a pair owned by a different channel is rejected. The configuration stays unchanged and cfg_err becomes 1. An accepted write updates the channel named by cfg_ch and clears cfg_err. Rewriting a channel's own pair is accepted.
- R3: ack_pin[p] is high exactly while eng_strobe is high for the channel that owns pair p. A strobe on a channel that owns no pair drives no acknowledge pin.
- R4: In level mode (cfg_edge = 0), xfer_req of the owning channel follows the active level of its pin, two clock cycles after the pin changes. It is held low during that channel's strobe and is sampled again afterwards.
- R5: In edge mode (cfg_edge = 1), an inactive-to-active transition on the pin latches a request. The request holds until the channel's strobe. A pin that stays active after the strobe raises no new request.
- R6: With cfg_act_low = 1, the low pin level is the active level. With cfg_act_low = 0, the high level is active.
- R7: A channel that owns no pair presents int_req of the same index on xfer_req, and request pin activity has no effect on it.
- R8: When a channel has cfg_term = 1 (input role), eng_stop for that channel is high during its strobe while the synchronised term_in is high and eng_flyby is low.
- R9: During a fly-by transfer (eng_flyby = 1), term_in has no effect and eng_stop stays 0.
- R10: term_oe is high while any channel has cfg_term = 2 (output role). term_out is high exactly while such a channel strobes with eng_last high.
- R11: A request pin affects only the channel that owns it. All other channels show no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel written |
| cfg_pin_en | input | 1 | Channel claims a pin pair |
| cfg_pin_sel | input | 2 | Pair index, 0 = A to 3 = D |
| cfg_edge | input | 1 | 1 = edge sensing, 0 = level sensing |
| cfg_act_low | input | 1 | 1 = low level is active |
| cfg_term | input | 2 | Terminate role: 0 unused, 1 input, 2 output |
| cfg_err | output | 1 | Last configuration write was rejected |
| req_pin | input | 4 | Asynchronous request pins |
| ack_pin | output | 4 | Acknowledge pins |
| int_req | input | 4 | Internal peripheral requests per channel |
| xfer_req | output | 4 | Transfer request per channel to the engine |
| eng_strobe | input | 4 | Engine transfer strobe per channel |
| eng_last | input | 4 | Strobed transfer is the last of its sequence |
| eng_flyby | input | 1 | Current transfer is fly-by |
| eng_stop | output | 4 | Stop-after-this-access request to the engine |
| term_in | input | 1 | Terminate line input value |
| term_out | output | 1 | Terminate line output value |
| term_oe | output | 1 | Terminate line output enable |

## Verification
The main sweep maps every channel onto every pair in all four combinations of sensing mode and polarity. A wrong pin index, a wrong acknowledge routing or a polarity inversion shows up as a request or an acknowledge on the wrong bit. After each strobe with the pin still active, level mode must raise the request again and edge mode must not, which separates the two modes. Separate sequences try a conflicting claim, a self-rewrite and pin-less channels, and they drive terminate in both roles with and without fly-by.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;
  typedef enum logic [1:0] {
    TERM_OFF = 2'd0,
    TERM_IN  = 2'd1,
    TERM_OUT = 2'd2
  } term_mode_e;

  typedef struct packed {
    logic       edge_mode;
    logic       act_low;
    term_mode_e term;
  } sense_cfg_t;
endpackage

// File: rtl/dmarr_sync.sv
module dmarr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dmarr_cfg.sv
module dmarr_cfg
  import dmarr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int PW  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CW-1:0]          cfg_ch,
  input  logic                   cfg_pin_en,
  input  logic [PW-1:0]          cfg_pin_sel,
  input  sense_cfg_t             cfg_sense,
  output logic [NCH-1:0]         pin_en,
  output logic [NCH-1:0][PW-1:0] pin_sel,
  output sense_cfg_t [NCH-1:0]   sense,
  output logic                   cfg_err
);
  logic [NCH-1:0]         en_q, en_n;
  logic [NCH-1:0][PW-1:0] sel_q, sel_n;
  sense_cfg_t [NCH-1:0]   sense_q, sense_n;
  logic                   err_q, err_n;
  logic                   conflict;

  always_comb begin
    conflict = 1'b0;
    for (int j = 0; j < NCH; j++) begin
      if (cfg_pin_en && en_q[j] && (sel_q[j] == cfg_pin_sel) && (j != int'(cfg_ch)))
        conflict = 1'b1;
    end
  end

  always_comb begin
    en_n    = en_q;
    sel_n   = sel_q;
    sense_n = sense_q;
    err_n   = err_q;
    if (cfg_we) begin
      if (conflict) begin
        err_n = 1'b1;
      end else begin
        err_n           = 1'b0;
        en_n[cfg_ch]    = cfg_pin_en;
        sel_n[cfg_ch]   = cfg_pin_sel;
        sense_n[cfg_ch] = cfg_sense;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NCH; j++) begin
        en_q[j]    <= (j < 2);
        sel_q[j]   <= (j < 2) ? PW'(j) : '0;
        sense_q[j] <= '{edge_mode: 1'b0, act_low: 1'b0, term: TERM_OFF};
      end
      err_q <= 1'b0;
    end else begin
      en_q    <= en_n;
      sel_q   <= sel_n;
      sense_q <= sense_n;
      err_q   <= err_n;
    end
  end

  assign pin_en  = en_q;
  assign pin_sel = sel_q;
  assign sense   = sense_q;
  assign cfg_err = err_q;

  for (genvar a = 0; a < NCH; a++) begin : g_pa
    for (genvar b = a + 1; b < NCH; b++) begin : g_pb
      assert_pair_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_q[a] && en_q[b] && (sel_q[a] == sel_q[b])));
    end
  end

  assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && conflict) |=> (err_q && $stable(en_q) && $stable(sel_q) && $stable(sense_q)));
endmodule

// File: rtl/dmarr_req_cond.sv
module dmarr_req_cond
  import dmarr_pkg::*;
#(
  parameter int NPIN = 4,
  parameter int PW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_s,
  input  logic            pin_en,
  input  logic [PW-1:0]   pin_sel,
  input  sense_cfg_t      sense,
  input  logic            strobe,
  input  logic            int_req,
  output logic            xfer_req,
  output logic            ack
);
  logic act_lvl;
  logic prev_q, prev_n;
  logic pend_q, pend_n;
  logic rise;

  assign act_lvl = pins_s[pin_sel] ^ sense.act_low;
  assign rise    = act_lvl && !prev_q;

  always_comb begin
    prev_n = act_lvl;
    pend_n = pend_q;
    if (!pin_en || !sense.edge_mode) begin
      pend_n = 1'b0;
    end else begin
      if (strobe) pend_n = 1'b0;
      if (rise)   pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    if (!pin_en)              xfer_req = int_req;
    else if (sense.edge_mode) xfer_req = pend_q;
    else                      xfer_req = act_lvl && !strobe;
  end

  assign ack = strobe && pin_en;

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && sense.edge_mode && pend_q && !strobe) |=> (pend_q || !pin_en || !sense.edge_mode));

  assert_level_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && !sense.edge_mode && strobe) |-> !xfer_req);
endmodule

// File: rtl/dmarr_term.sv
module dmarr_term
  import dmarr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 term_in,
  input  sense_cfg_t [NCH-1:0] sense,
  input  logic [NCH-1:0]       strobe,
  input  logic [NCH-1:0]       last,
  input  logic                 flyby,
  output logic [NCH-1:0]       eng_stop,
  output logic                 term_out,
  output logic                 term_oe
);
  logic           term_s;
  logic [NCH-1:0] is_in, is_out;

  dmarr_sync #(.W(1), .STAGES(STAGES)) u_tsync (
    .clk(clk), .rst_n(rst_n), .d(term_in), .q(term_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_role
    assign is_in[c]    = (sense[c].term == TERM_IN);
    assign is_out[c]   = (sense[c].term == TERM_OUT);
    assign eng_stop[c] = strobe[c] && is_in[c] && term_s && !flyby;
  end

  assign term_out = |(strobe & last & is_out);
  assign term_oe  = |is_out;

  assert_flyby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flyby |-> (eng_stop == '0));

  assert_drive_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_out |-> term_oe);
endmodule

// File: rtl/dmarr_top.sv
module dmarr_top
  import dmarr_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(NCH),
  localparam int PW = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CW-1:0]   cfg_ch,
  input  logic            cfg_pin_en,
  input  logic [PW-1:0]   cfg_pin_sel,
  input  logic            cfg_edge,
  input  logic            cfg_act_low,
  input  logic [1:0]      cfg_term,
  output logic            cfg_err,
  input  logic [NPIN-1:0] req_pin,
  output logic [NPIN-1:0] ack_pin,
  input  logic [NCH-1:0]  int_req,
  output logic [NCH-1:0]  xfer_req,
  input  logic [NCH-1:0]  eng_strobe,
  input  logic [NCH-1:0]  eng_last,
  input  logic            eng_flyby,
  output logic [NCH-1:0]  eng_stop,
  input  logic            term_in,
  output logic            term_out,
  output logic            term_oe
);
  sense_cfg_t                 wr_sense;
  logic [NCH-1:0]             pin_en;
  logic [NCH-1:0][PW-1:0]     pin_sel;
  sense_cfg_t [NCH-1:0]       sense;
  logic [NPIN-1:0]            pins_s;
  logic [NCH-1:0]             ch_ack;

  assign wr_sense = '{edge_mode: cfg_edge, act_low: cfg_act_low, term: term_mode_e'(cfg_term)};

  dmarr_cfg #(.NCH(NCH), .CW(CW), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_pin_en(cfg_pin_en), .cfg_pin_sel(cfg_pin_sel), .cfg_sense(wr_sense),
    .pin_en(pin_en), .pin_sel(pin_sel), .sense(sense), .cfg_err(cfg_err)
  );

  dmarr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_psync (
    .clk(clk), .rst_n(rst_n), .d(req_pin), .q(pins_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmarr_req_cond #(.NPIN(NPIN), .PW(PW)) u_cond (
      .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .pin_en(pin_en[c]),
      .pin_sel(pin_sel[c]), .sense(sense[c]), .strobe(eng_strobe[c]),
      .int_req(int_req[c]), .xfer_req(xfer_req[c]), .ack(ch_ack[c])
    );
  end

  always_comb begin
    ack_pin = '0;
    for (int p = 0; p < NPIN; p++) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_ack[c] && (int'(pin_sel[c]) == p)) ack_pin[p] = 1'b1;
      end
    end
  end

  dmarr_term #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_term (
    .clk(clk), .rst_n(rst_n), .term_in(term_in), .sense(sense),
    .strobe(eng_strobe), .last(eng_last), .flyby(eng_flyby),
    .eng_stop(eng_stop), .term_out(term_out), .term_oe(term_oe)
  );

  assert_ack_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pin != '0) |-> (eng_strobe != '0));
endmodule

// File: tb/dmarr_top_test.sv
module dmarr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, cfg_pin_en = 0, cfg_edge = 0, cfg_act_low = 0;
  logic [1:0] cfg_ch = 0, cfg_pin_sel = 0, cfg_term = 0;
  logic       cfg_err;
  logic [3:0] req_pin = 0, ack_pin, int_req = 0, xfer_req;
  logic [3:0] eng_strobe = 0, eng_last = 0, eng_stop;
  logic       eng_flyby = 0, term_in = 0, term_out, term_oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmarr_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_pin_en(cfg_pin_en), .cfg_pin_sel(cfg_pin_sel), .cfg_edge(cfg_edge),
    .cfg_act_low(cfg_act_low), .cfg_term(cfg_term), .cfg_err(cfg_err),
    .req_pin(req_pin), .ack_pin(ack_pin), .int_req(int_req), .xfer_req(xfer_req),
    .eng_strobe(eng_strobe), .eng_last(eng_last), .eng_flyby(eng_flyby),
    .eng_stop(eng_stop), .term_in(term_in), .term_out(term_out), .term_oe(term_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int ch, input bit en, input int sel, input bit ed, input bit al, input int tm);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_pin_en = en; cfg_pin_sel = 2'(sel);
    cfg_edge = ed; cfg_act_low = al; cfg_term = 2'(tm);
    @(negedge clk);
    cfg_we = 0;
    #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #100_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R1 reset state
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 ack_pin", ack_pin, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 term_oe", term_oe, 0);
    req_pin = 4'b0001; wait_n(3);
    chk("R1 pinA to ch0", xfer_req, 4'b0001);
    req_pin = 4'b0011; wait_n(3);
    chk("R1 pinB to ch1", xfer_req, 4'b0011);
    @(negedge clk); eng_strobe = 4'b0010; #1;
    chk("R1 ch1 acks pin B", ack_pin, 4'b0010);
    @(negedge clk); eng_strobe = 0; req_pin = 0; wait_n(4);

    // R2 conflict and acceptance
    wr(2, 1, 0, 0, 0, 0);
    chk("R2 conflict err", cfg_err, 1);
    @(negedge clk); eng_strobe = 4'b0100; #1;
    chk("R2 rejected claim drives no ack", ack_pin, 0);
    @(negedge clk); eng_strobe = 0;
    wr(2, 1, 2, 0, 0, 0);
    chk("R2 accepted clears err", cfg_err, 0);
    @(negedge clk); eng_strobe = 4'b0100; #1;
    chk("R3 ch2 acks pin C", ack_pin, 4'b0100);
    @(negedge clk); eng_strobe = 0;
    wr(0, 1, 0, 0, 0, 0);
    chk("R2 self rewrite accepted", cfg_err, 0);

    // R7 pin-less channel
    int_req = 4'b1000; #1;
    chk("R7 int_req passthrough", xfer_req[3], 1);
    req_pin = 4'b1111; wait_n(4);
    chk("R7 pins ignored by ch3", xfer_req[3], 1);
    int_req = 0; #1;
    chk("R7 int_req low", xfer_req[3], 0);
    @(negedge clk); eng_strobe = 4'b1000; #1;
    chk("R3 pinless strobe no ack", ack_pin, 0);
    @(negedge clk); eng_strobe = 0; req_pin = 0; wait_n(4);

    // R8 R9 terminate input
    wr(2, 1, 2, 0, 0, 1);
    chk("R10 oe low in input role", term_oe, 0);
    term_in = 1; wait_n(4);
    @(negedge clk); eng_strobe = 4'b0100; #1;
    chk("R8 stop on term", eng_stop, 4'b0100);
    eng_flyby = 1; #1;
    chk("R9 flyby ignores term", eng_stop, 0);
    @(negedge clk); eng_strobe = 0; eng_flyby = 0; term_in = 0; wait_n(4);
    @(negedge clk); eng_strobe = 4'b0100; #1;
    chk("R8 no stop without term", eng_stop, 0);
    @(negedge clk); eng_strobe = 0;

    // R10 terminate output
    wr(3, 0, 0, 0, 0, 2);
    chk("R10 oe high", term_oe, 1);
    @(negedge clk); eng_strobe = 4'b1000; eng_last = 0; #1;
    chk("R10 not last", term_out, 0);
    eng_last = 4'b1000; #1;
    chk("R10 last strobe", term_out, 1);
    eng_strobe = 4'b0100; eng_last = 4'b0100; #1;
    chk("R10 other channel last", term_out, 0);
    @(negedge clk); eng_strobe = 0; eng_last = 0;
    wr(3, 0, 0, 0, 0, 0);
    chk("R10 oe released", term_oe, 0);

    // sweep: every channel, every pair, every mode
    for (int c = 0; c < 4; c++) wr(c, 0, 0, 0, 0, 0);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int m = 0; m < 4; m++) begin
          bit ed = m[1];
          bit al = m[0];
          req_pin[p] = al;
          wait_n(4);
          wr(c, 1, p, ed, al, 0);
          wait_n(3);
          chk("R4/R5/R6 idle no request", xfer_req, 0);
          req_pin[p] = ~al;
          wait_n(5);
          chk("R11 R6 request on owner only", xfer_req, 32'(1 << c));
          @(negedge clk); eng_strobe[c] = 1; #1;
          chk("R3 ack on owned pin", ack_pin, 32'(1 << p));
          chk(ed ? "R5 held during strobe" : "R4 masked during strobe", xfer_req[c], ed);
          @(negedge clk); eng_strobe = 0; #1;
          chk(ed ? "R5 no rerequest" : "R4 resampled", xfer_req[c], !ed);
          req_pin[p] = al;
          wait_n(4);
          chk("R4 R5 released", xfer_req, 0);
          wr(c, 0, 0, 0, 0, 0);
        end
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule